// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This block chooses where each operand of a five-stage integer pipeline comes from when a result it needs has not yet reached the register file. It looks at the instruction class and register fields held in the ID/EX, EX/MEM and MEM/WB pipeline registers. For each operand consumer it produces an encoded select: take the register-file value, the ALU result held in EX/MEM, the ALU result held in MEM/WB, or the load data held in MEM/WB.

There are four consumers. Two are the ALU operand inputs of the instruction in EX. The third is the zero test that resolves a branch in EX. The fourth is the write-data input of the data memory, used by a store that sits in EX/MEM. The block is purely combinational. The datapath muxes, the pipeline registers and stall control sit outside it and take the selects as they are.

Top module: `fwd_unit`

## Requirements
- R1: Class codes are 0 no-op, 1 register-register ALU, 2 register-immediate ALU, 3 load, 4 store, 5 branch, and 6 and 7 act as no-op. Classes 1, 2 and 3 write a register: class 1 writes `rd`, and classes 2 and 3 write `rt`. No other class writes a register.
- R2: Select codes are 0 register file, 1 EX/MEM ALU result, 2 MEM/WB ALU result and 3 MEM/WB load data. `alu_a_sel` resolves the `rs` field of an ID/EX instruction of class 1, 2, 3 or 4.
- R3: `alu_b_sel` resolves the `rt` field of an ID/EX instruction of class 1 or 4. For class 4 this is the store value carried towards memory.
- R4: `zero_sel` resolves the `rs` field of an ID/EX instruction of class 5.
- R5: When EX/MEM and MEM/WB both write the register an operand reads, the EX/MEM result is chosen (code 1).
- R6: An EX/MEM instruction of class 3 is never a source. An operand it would match falls through to MEM/WB or to the register file.
- R7: A matching MEM/WB instruction gives code 2 when it is class 1 or 2, and code 3 when it is class 3.
- R8: `st_data_sel` resolves the `rt` field of an EX/MEM instruction of class 4 against MEM/WB only. Its codes are 0, 2 or 3, never 1.
- R9: An operand or destination of register 0 is never forwarded. Its select is 0.
- R10: Instructions of class 0, 4, 5, 6 or 7 in EX/MEM or MEM/WB never act as sources.
- R11: A consumer that the current instruction class does not use has select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_cls | input | 3 | Class of the instruction in ID/EX |
| idex_rs | input | REG_W | First source field in ID/EX |
| idex_rt | input | REG_W | Second source field in ID/EX |
| exmem_cls | input | 3 | Class of the instruction in EX/MEM |
| exmem_rt | input | REG_W | rt field in EX/MEM (destination or store source) |
| exmem_rd | input | REG_W | rd field in EX/MEM |
| memwb_cls | input | 3 | Class of the instruction in MEM/WB |
| memwb_rt | input | REG_W | rt field in MEM/WB |
| memwb_rd | input | REG_W | rd field in MEM/WB |
| alu_a_sel | output | 2 | Source select for ALU operand A |
| alu_b_sel | output | 2 | Source select for ALU operand B / store value |
| zero_sel | output | 2 | Source select for the branch zero test |
| st_data_sel | output | 2 | Source select for the data-memory write data |

## Verification
The table of patterns sets one producer against one consumer for each pairing of classes. These patterns show that the destination field is taken by class, and that each sink is active only for the classes that use it. Patterns where both stages match show the priority. Patterns with a load in EX/MEM separate fall-through to MEM/WB from fall-back to the register file. Patterns that use register 0, store or branch producers, and unused class codes show that such matches are rejected. A sweep over every register index with an EX/MEM writer shows that the comparators cover the full index range, and that index 0 is excluded.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int CLS_W     = 3;
  localparam int SEL_W     = 2;
  localparam int NUM_SINKS = 4;

  localparam logic [CLS_W-1:0] CLS_NOP    = 3'd0;
  localparam logic [CLS_W-1:0] CLS_RR     = 3'd1;
  localparam logic [CLS_W-1:0] CLS_RI     = 3'd2;
  localparam logic [CLS_W-1:0] CLS_LOAD   = 3'd3;
  localparam logic [CLS_W-1:0] CLS_STORE  = 3'd4;
  localparam logic [CLS_W-1:0] CLS_BRANCH = 3'd5;

  localparam logic [SEL_W-1:0] SEL_REGFILE  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_EXM_ALU  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_MWB_ALU  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_MWB_LOAD = 2'd3;

  // sink slots
  localparam int SINK_A  = 0;
  localparam int SINK_B  = 1;
  localparam int SINK_Z  = 2;
  localparam int SINK_ST = 3;
endpackage

// File: rtl/fwd_dest_decode.sv
module fwd_dest_decode
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [CLS_W-1:0] cls,
  input  logic [REG_W-1:0] rt,
  input  logic [REG_W-1:0] rd,
  output logic [REG_W-1:0] dest,
  output logic             alu_src,
  output logic             load_src
);
  logic writes;

  always_comb begin
    dest     = '0;
    writes   = 1'b0;
    alu_src  = 1'b0;
    load_src = 1'b0;
    unique case (cls)
      CLS_RR:   begin dest = rd; writes = 1'b1; end
      CLS_RI:   begin dest = rt; writes = 1'b1; end
      CLS_LOAD: begin dest = rt; writes = 1'b1; end
      default:  begin dest = '0; writes = 1'b0; end
    endcase
    // register 0 is hard-wired: never a forwarding destination
    if (writes && (dest != '0)) begin
      alu_src  = (cls != CLS_LOAD);
      load_src = (cls == CLS_LOAD);
    end
  end

  always_comb begin
    AST_SRC_EXCLUSIVE: assert (!(alu_src && load_src)); // R7
  end
endmodule

// File: rtl/fwd_src_pick.sv
module fwd_src_pick
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             need,
  input  logic             allow_exm,
  input  logic [REG_W-1:0] exm_dest,
  input  logic             exm_alu,
  input  logic [REG_W-1:0] mwb_dest,
  input  logic             mwb_alu,
  input  logic             mwb_ld,
  output logic [SEL_W-1:0] sel
);
  logic hit_exm;
  logic hit_mwb;

  always_comb begin
    hit_exm = need && allow_exm && exm_alu && (exm_dest == src);
    hit_mwb = need && (mwb_alu || mwb_ld) && (mwb_dest == src);
    if (hit_exm)                sel = SEL_EXM_ALU;
    else if (hit_mwb && mwb_ld) sel = SEL_MWB_LOAD;
    else if (hit_mwb)           sel = SEL_MWB_ALU;
    else                        sel = SEL_REGFILE;
  end

  always_comb begin
    AST_REG0_NOT_FWD: assert (!((src == '0) && (sel != SEL_REGFILE))); // R9
    AST_IDLE_SINK:    assert (need || (sel == SEL_REGFILE));            // R11
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [CLS_W-1:0] idex_cls,
  input  logic [REG_W-1:0] idex_rs,
  input  logic [REG_W-1:0] idex_rt,
  input  logic [CLS_W-1:0] exmem_cls,
  input  logic [REG_W-1:0] exmem_rt,
  input  logic [REG_W-1:0] exmem_rd,
  input  logic [CLS_W-1:0] memwb_cls,
  input  logic [REG_W-1:0] memwb_rt,
  input  logic [REG_W-1:0] memwb_rd,
  output logic [SEL_W-1:0] alu_a_sel,
  output logic [SEL_W-1:0] alu_b_sel,
  output logic [SEL_W-1:0] zero_sel,
  output logic [SEL_W-1:0] st_data_sel
);
  logic [REG_W-1:0] exm_dest, mwb_dest;
  logic             exm_alu, exm_ld, mwb_alu, mwb_ld;

  fwd_dest_decode #(.REG_W(REG_W)) u_exm_dec (
    .cls(exmem_cls), .rt(exmem_rt), .rd(exmem_rd),
    .dest(exm_dest), .alu_src(exm_alu), .load_src(exm_ld)
  );

  fwd_dest_decode #(.REG_W(REG_W)) u_mwb_dec (
    .cls(memwb_cls), .rt(memwb_rt), .rd(memwb_rd),
    .dest(mwb_dest), .alu_src(mwb_alu), .load_src(mwb_ld)
  );

  // per-sink source field, usage and whether EX/MEM may feed it
  logic [REG_W-1:0] sink_src  [NUM_SINKS];
  logic             sink_need [NUM_SINKS];
  logic             sink_exm  [NUM_SINKS];
  logic [SEL_W-1:0] sink_sel  [NUM_SINKS];

  always_comb begin
    sink_src[SINK_A]   = idex_rs;
    sink_need[SINK_A]  = (idex_cls == CLS_RR) || (idex_cls == CLS_RI) ||
                         (idex_cls == CLS_LOAD) || (idex_cls == CLS_STORE);
    sink_exm[SINK_A]   = 1'b1;
    sink_src[SINK_B]   = idex_rt;
    sink_need[SINK_B]  = (idex_cls == CLS_RR) || (idex_cls == CLS_STORE);
    sink_exm[SINK_B]   = 1'b1;
    sink_src[SINK_Z]   = idex_rs;
    sink_need[SINK_Z]  = (idex_cls == CLS_BRANCH);
    sink_exm[SINK_Z]   = 1'b1;
    // store in EX/MEM: only MEM/WB is older than it
    sink_src[SINK_ST]  = exmem_rt;
    sink_need[SINK_ST] = (exmem_cls == CLS_STORE);
    sink_exm[SINK_ST]  = 1'b0;
  end

  for (genvar g = 0; g < NUM_SINKS; g++) begin : g_sink
    fwd_src_pick #(.REG_W(REG_W)) u_pick (
      .src(sink_src[g]), .need(sink_need[g]), .allow_exm(sink_exm[g]),
      .exm_dest(exm_dest), .exm_alu(exm_alu),
      .mwb_dest(mwb_dest), .mwb_alu(mwb_alu), .mwb_ld(mwb_ld),
      .sel(sink_sel[g])
    );
  end

  assign alu_a_sel   = sink_sel[SINK_A];
  assign alu_b_sel   = sink_sel[SINK_B];
  assign zero_sel    = sink_sel[SINK_Z];
  assign st_data_sel = sink_sel[SINK_ST];

  always_comb begin
    AST_EXM_NOT_LOAD: assert (!((alu_a_sel == SEL_EXM_ALU) && exm_ld)); // R6
    AST_EXM_ALU_CLS:  assert (!((alu_a_sel == SEL_EXM_ALU || alu_b_sel == SEL_EXM_ALU ||
                                 zero_sel == SEL_EXM_ALU) &&
                                !(exmem_cls == CLS_RR || exmem_cls == CLS_RI))); // R10
    AST_LOAD_SRC_CLS: assert (!((alu_a_sel == SEL_MWB_LOAD || alu_b_sel == SEL_MWB_LOAD ||
                                 zero_sel == SEL_MWB_LOAD || st_data_sel == SEL_MWB_LOAD) &&
                                (memwb_cls != CLS_LOAD)));                        // R7
    AST_ZERO_BRANCH:  assert ((zero_sel == SEL_REGFILE) || (idex_cls == CLS_BRANCH)); // R4
    AST_B_USERS:      assert ((alu_b_sel == SEL_REGFILE) ||
                              (idex_cls == CLS_RR) || (idex_cls == CLS_STORE));  // R3
    AST_STDATA_NO_EXM: assert (st_data_sel != SEL_EXM_ALU);                      // R8
  end
endmodule

// File: tb/fwd_unit_bench.sv
`timescale 1ns/100ps
module fwd_unit_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0] idc, xc, mc;
  logic [4:0] rs, rt, xrt, xrd, mrt, mrd;
  logic [1:0] a_sel, b_sel, z_sel, s_sel;

  fwd_unit u_fwd_unit (
    .idex_cls(idc), .idex_rs(rs), .idex_rt(rt),
    .exmem_cls(xc), .exmem_rt(xrt), .exmem_rd(xrd),
    .memwb_cls(mc), .memwb_rt(mrt), .memwb_rd(mrd),
    .alu_a_sel(a_sel), .alu_b_sel(b_sel), .zero_sel(z_sel), .st_data_sel(s_sel)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // class codes as required by R1
  localparam logic [2:0] NOP = 3'd0, RR = 3'd1, RI = 3'd2, LD = 3'd3,
                         ST = 3'd4, BR = 3'd5, X6 = 3'd6;

  function automatic logic [50:0] mk(logic [2:0] ic, logic [4:0] s, logic [4:0] t,
                                     logic [2:0] ec, logic [4:0] et, logic [4:0] ed,
                                     logic [2:0] wc, logic [4:0] wt, logic [4:0] wd,
                                     logic [1:0] ea, logic [1:0] eb, logic [1:0] ez,
                                     logic [1:0] es, logic [3:0] rq);
    return {ic, s, t, ec, et, ed, wc, wt, wd, ea, eb, ez, es, rq};
  endfunction

  localparam int NV = 23;
  localparam logic [50:0] VEC [NV] = '{
    mk(RR, 1, 2,  RR, 9, 1,    NOP, 0, 0,   1, 0, 0, 0, 2),  // R2 EX/MEM rd to A
    mk(RR, 1, 2,  NOP, 0, 0,   RR, 0, 2,    0, 2, 0, 0, 3),  // R3 MEM/WB rd to B
    mk(RR, 3, 3,  RI, 3, 9,    RR, 0, 3,    1, 1, 0, 0, 5),  // R5 priority
    mk(RR, 4, 5,  LD, 4, 0,    RR, 0, 4,    2, 0, 0, 0, 6),  // R6 load skipped, MEM/WB used
    mk(RR, 4, 5,  LD, 4, 0,    NOP, 0, 0,   0, 0, 0, 0, 6),  // R6 load skipped, regfile
    mk(RI, 6, 7,  NOP, 0, 0,   LD, 6, 0,    3, 0, 0, 0, 7),  // R7 load data to A
    mk(RI, 6, 7,  RR, 0, 7,    NOP, 0, 0,   0, 0, 0, 0, 11), // R11 RI has no B
    mk(RR, 8, 9,  RR, 8, 10,   NOP, 0, 0,   0, 0, 0, 0, 1),  // R1 RR writes rd not rt
    mk(RR, 8, 9,  RI, 9, 8,    NOP, 0, 0,   0, 1, 0, 0, 1),  // R1 RI writes rt not rd
    mk(BR, 11, 12, RR, 0, 11,  NOP, 0, 0,   0, 0, 1, 0, 4),  // R4 zero test from EX/MEM
    mk(BR, 11, 12, NOP, 0, 0,  LD, 11, 0,   0, 0, 3, 0, 4),  // R4 zero test from load
    mk(ST, 13, 14, RR, 0, 14,  RI, 13, 0,   2, 1, 0, 0, 3),  // R3 store value path
    mk(NOP, 0, 0, ST, 15, 0,   LD, 15, 0,   0, 0, 0, 3, 8),  // R8 load to store data
    mk(NOP, 0, 0, ST, 15, 0,   RR, 0, 15,   0, 0, 0, 2, 8),  // R8 ALU to store data
    mk(NOP, 0, 0, ST, 15, 0,   RI, 16, 0,   0, 0, 0, 0, 8),  // R8 no match
    mk(RR, 0, 0,  RR, 0, 0,    LD, 0, 0,    0, 0, 0, 0, 9),  // R9 register 0
    mk(NOP, 0, 0, ST, 0, 0,    LD, 0, 0,    0, 0, 0, 0, 9),  // R9 store of r0
    mk(RR, 17, 18, ST, 17, 17, BR, 18, 18,  0, 0, 0, 0, 10), // R10 store/branch not sources
    mk(LD, 19, 20, RR, 0, 20,  RR, 0, 19,   2, 0, 0, 0, 2),  // R2 load base from MEM/WB
    mk(NOP, 21, 21, RR, 0, 21, NOP, 0, 0,   0, 0, 0, 0, 11), // R11 no-op uses nothing
    mk(RR, 22, 23, X6, 22, 22, X6, 23, 23,  0, 0, 0, 0, 10), // R10 unused code 6
    mk(ST, 1, 15, ST, 15, 0,   LD, 15, 0,   0, 3, 0, 3, 8),  // R8 both store paths
    mk(RR, 2, 2,  NOP, 0, 0,   RI, 2, 0,    2, 2, 0, 0, 7)   // R7 ALU result code 2
  };

  task automatic chk(string what, int rq, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic apply(logic [50:0] v);
    @(negedge clk);
    {idc, rs, rt, xc, xrt, xrd, mc, mrt, mrd} = v[50:12];
    @(posedge clk);
    #1;
  endtask

  initial begin
    {idc, rs, rt, xc, xrt, xrd, mc, mrt, mrd} = '0;
    repeat (2) @(posedge clk);
    #1;
    // all-idle state: every select reads the register file (R11)
    chk("idle A", 11, a_sel, 2'd0);
    chk("idle B", 11, b_sel, 2'd0);
    chk("idle Z", 11, z_sel, 2'd0);
    chk("idle ST", 11, s_sel, 2'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      chk($sformatf("vec%0d A", i), int'(VEC[i][3:0]), a_sel, VEC[i][11:10]);
      chk($sformatf("vec%0d B", i), int'(VEC[i][3:0]), b_sel, VEC[i][9:8]);
      chk($sformatf("vec%0d Z", i), int'(VEC[i][3:0]), z_sel, VEC[i][7:6]);
      chk($sformatf("vec%0d ST", i), int'(VEC[i][3:0]), s_sel, VEC[i][5:4]);
    end

    // R9 and R2: every index with an EX/MEM writer; index 0 stays on the register file
    for (int r = 0; r < 32; r++) begin
      apply(mk(RR, 5'(r), 5'(r), RR, 0, 5'(r), LD, 5'(r), 0, 0, 0, 0, 0, 0));
      chk($sformatf("sweep r%0d A", r), (r == 0) ? 9 : 2, a_sel, (r == 0) ? 2'd0 : 2'd1);
      chk($sformatf("sweep r%0d B", r), (r == 0) ? 9 : 5, b_sel, (r == 0) ? 2'd0 : 2'd1);
    end

    // R6: load in EX/MEM plus load in MEM/WB on same register gives load data
    apply(mk(BR, 9, 0, LD, 9, 0, LD, 9, 0, 0, 0, 0, 0, 0));
    chk("load over load Z", 6, z_sel, 2'd3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R0 watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule